// File: doc/BRIEF.md
# Two-Register Stack Datapath

This block holds the top two entries of a small data stack in a pair of 16-bit registers: a top-of-stack register (TOS) and a next-on-stack register (NOS). A sequencer elsewhere decodes each program word and drives plain strobes and selects into the block. The select code picks what TOS loads from: the function-unit result, the switch bank, the current program word or NOS. A six-bit function code, taken straight from the low bits of the opcode, chooses the arithmetic or logic operation of the function unit on TOS and NOS.

A separate display register captures TOS on a strobe and feeds a display driver outside the block. Every register clears asynchronously on `clr`. All pins are control or level data sampled on the rising clock edge. No stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. A strobe that is high at a rising edge takes effect at that edge, and the result is visible on the outputs straight after it.

Top module: `tos_nos_datapath`

## Requirements
- R1: While `clr` is high, `tos`, `nos` and `disp` are all zero, without waiting for a clock edge.
- R2: With `n_load` high at a rising edge, `nos` takes the value `tos` had before that edge, and `tos` is unaffected by `n_load` (duplicate).
- R3: With a strobe low at a rising edge, the register it controls keeps its value (`t_load` for `tos`, `n_load` for `nos`, `disp_load` for `disp`).
- R4: `t_load` with `src_sel` = 2'b01 loads `tos` with the 8 switch bits in bits 7..0 and zeros in bits 15..8.
- R5: `t_load` with `src_sel` = 2'b10 loads `tos` with `prog_word`.
- R6: `t_load` with `src_sel` = 2'b11 loads `tos` with `nos`.
- R7: `t_load` with `src_sel` = 2'b00 and `func_code` = 6'h10 loads `tos` with `tos + nos` modulo 2^16, and no carry is kept.
- R8: `func_code` = 6'h18 (with `src_sel` = 2'b00) loads `tos` with `tos` shifted left by one; bit 15 is dropped and bit 0 becomes 0.
- R9: `func_code` = 6'h12 (with `src_sel` = 2'b00) loads `tos` with `tos + 1` modulo 2^16.
- R10: `func_code` = 6'h1C (with `src_sel` = 2'b00) loads `tos` with the bitwise complement of `tos`.
- R11: Any other `func_code`, with `src_sel` = 2'b00 and `t_load`, leaves `tos` unchanged.
- R12: `disp_load` at a rising edge copies the pre-edge `tos` into `disp`.
- R13: With `t_load` and `n_load` both high at one edge, `nos` takes the old `tos` while `tos` takes its new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Asynchronous clear, active high |
| t_load | input | 1 | Load strobe for TOS |
| n_load | input | 1 | Load strobe for NOS (NOS takes TOS) |
| disp_load | input | 1 | Load strobe for the display register |
| src_sel | input | 2 | TOS source: 00 function, 01 switches, 10 program word, 11 NOS |
| func_code | input | 6 | Function-unit operation code |
| switches | input | 8 | Switch bank value |
| prog_word | input | 16 | Current program word |
| tos | output | 16 | Top-of-stack register |
| nos | output | 16 | Next-on-stack register |
| disp | output | 16 | Display register |

## Verification
Every state bit of the block sits directly on an output, so a wrong TOS, NOS or display value is visible at the ports in the cycle right after the edge that produced it. A source-select or function-code decode error therefore shows in one cycle on `tos`. A fault in NOS capture shows on `nos` at once, and it shows again on `tos` one add later. The reference model is compared on all three outputs after every edge, and once straight after an asynchronous clear, so any wrong state is reported within one clock.

// File: rtl/tnd_pkg.sv
package tnd_pkg;
  localparam int FC_W = 6;

  typedef enum logic [1:0] {
    SRC_FUNC   = 2'b00,
    SRC_SWITCH = 2'b01,
    SRC_PROG   = 2'b10,
    SRC_NOS    = 2'b11
  } src_sel_e;

  localparam logic [FC_W-1:0] FC_ADD    = 6'h10;
  localparam logic [FC_W-1:0] FC_INC    = 6'h12;
  localparam logic [FC_W-1:0] FC_DOUBLE = 6'h18;
  localparam logic [FC_W-1:0] FC_INVERT = 6'h1C;
endpackage

// File: rtl/tnd_func_unit.sv
module tnd_func_unit
  import tnd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [FC_W-1:0] fc,
  output logic [W-1:0]    y
);
  always_comb begin
    case (fc)
      FC_ADD:    y = a + b;
      FC_INC:    y = a + W'(1);
      FC_DOUBLE: y = {a[W-2:0], 1'b0};
      FC_INVERT: y = ~a;
      default:   y = a;
    endcase
  end
endmodule

// File: rtl/tnd_src_mux.sv
module tnd_src_mux
  import tnd_pkg::*;
#(
  parameter int W    = 16,
  parameter int SW_W = 8
) (
  input  logic [1:0]      sel,
  input  logic [W-1:0]    func_y,
  input  logic [SW_W-1:0] switches,
  input  logic [W-1:0]    prog_word,
  input  logic [W-1:0]    nos,
  output logic [W-1:0]    y
);
  localparam int PAD = W - SW_W;

  logic [W-1:0] sw_ext;

  generate
    if (PAD > 0) begin : g_pad
      assign sw_ext = {{PAD{1'b0}}, switches};
    end else begin : g_nopad
      assign sw_ext = switches[W-1:0];
    end
  endgenerate

  always_comb begin
    case (src_sel_e'(sel))
      SRC_FUNC:   y = func_y;
      SRC_SWITCH: y = sw_ext;
      SRC_PROG:   y = prog_word;
      default:    y = nos;
    endcase
  end
endmodule

// File: rtl/tnd_load_reg.sv
module tnd_load_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or posedge clr) begin
    if (clr)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/tos_nos_datapath.sv
module tos_nos_datapath
  import tnd_pkg::*;
#(
  parameter int W    = 16,
  parameter int SW_W = 8
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            t_load,
  input  logic            n_load,
  input  logic            disp_load,
  input  logic [1:0]      src_sel,
  input  logic [FC_W-1:0] func_code,
  input  logic [SW_W-1:0] switches,
  input  logic [W-1:0]    prog_word,
  output logic [W-1:0]    tos,
  output logic [W-1:0]    nos,
  output logic [W-1:0]    disp
);
  logic [W-1:0] fu_y;
  logic [W-1:0] tos_d;

  tnd_func_unit #(.W(W)) u_fu (
    .a  (tos),
    .b  (nos),
    .fc (func_code),
    .y  (fu_y)
  );

  tnd_src_mux #(.W(W), .SW_W(SW_W)) u_mux (
    .sel       (src_sel),
    .func_y    (fu_y),
    .switches  (switches),
    .prog_word (prog_word),
    .nos       (nos),
    .y         (tos_d)
  );

  tnd_load_reg #(.W(W)) u_tos (
    .clk (clk), .clr (clr), .ld (t_load), .d (tos_d), .q (tos)
  );

  tnd_load_reg #(.W(W)) u_nos (
    .clk (clk), .clr (clr), .ld (n_load), .d (tos), .q (nos)
  );

  tnd_load_reg #(.W(W)) u_disp (
    .clk (clk), .clr (clr), .ld (disp_load), .d (tos), .q (disp)
  );
endmodule

// File: rtl/tnd_checker.sv
module tnd_checker
  import tnd_pkg::*;
#(
  parameter int W    = 16,
  parameter int SW_W = 8
) (
  input logic            clk,
  input logic            clr,
  input logic            t_load,
  input logic            n_load,
  input logic            disp_load,
  input logic [1:0]      src_sel,
  input logic [FC_W-1:0] func_code,
  input logic [SW_W-1:0] switches,
  input logic [W-1:0]    prog_word,
  input logic [W-1:0]    tos,
  input logic [W-1:0]    nos,
  input logic [W-1:0]    disp
);
  // R1: cleared state while clr is held
  always @(negedge clk) begin
    if (clr) begin
      a_r1_clear_zero: assert (tos == '0 && nos == '0 && disp == '0);
    end
  end

  // R2, R13: NOS captures the pre-edge TOS
  a_r2_nos_takes_tos: assert property (@(posedge clk) disable iff (clr)
    n_load |=> nos == $past(tos));

  // R3: registers hold without their strobe
  a_r3_tos_hold: assert property (@(posedge clk) disable iff (clr)
    !t_load |=> $stable(tos));
  a_r3_nos_hold: assert property (@(posedge clk) disable iff (clr)
    !n_load |=> $stable(nos));
  a_r3_disp_hold: assert property (@(posedge clk) disable iff (clr)
    !disp_load |=> $stable(disp));

  // R4: zero-extended switches
  a_r4_switch_src: assert property (@(posedge clk) disable iff (clr)
    (t_load && src_sel == 2'b01) |=> tos == W'($past(switches)));

  // R5: program word source
  a_r5_prog_src: assert property (@(posedge clk) disable iff (clr)
    (t_load && src_sel == 2'b10) |=> tos == $past(prog_word));

  // R6: NOS source
  a_r6_nos_src: assert property (@(posedge clk) disable iff (clr)
    (t_load && src_sel == 2'b11) |=> tos == $past(nos));

  // R7: wrapping add
  a_r7_add_wraps: assert property (@(posedge clk) disable iff (clr)
    (t_load && src_sel == 2'b00 && func_code == FC_ADD)
      |=> tos == W'($past(tos) + $past(nos)));

  // R11: unknown codes keep TOS
  a_r11_other_code_keeps: assert property (@(posedge clk) disable iff (clr)
    (t_load && src_sel == 2'b00 && func_code != FC_ADD && func_code != FC_INC
     && func_code != FC_DOUBLE && func_code != FC_INVERT) |=> $stable(tos));

  // R12: display capture
  a_r12_disp_copy: assert property (@(posedge clk) disable iff (clr)
    disp_load |=> disp == $past(tos));
endmodule

bind tos_nos_datapath tnd_checker #(.W(W), .SW_W(SW_W)) u_tnd_checker (
  .clk       (clk),
  .clr       (clr),
  .t_load    (t_load),
  .n_load    (n_load),
  .disp_load (disp_load),
  .src_sel   (src_sel),
  .func_code (func_code),
  .switches  (switches),
  .prog_word (prog_word),
  .tos       (tos),
  .nos       (nos),
  .disp      (disp)
);

// File: tb/tos_nos_datapath_bench.sv
`timescale 1ns/1ps
module tos_nos_datapath_bench;
  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic        t_load = 1'b0, n_load = 1'b0, disp_load = 1'b0;
  logic [1:0]  src_sel = 2'b00;
  logic [5:0]  func_code = 6'h00;
  logic [7:0]  switches = 8'h00;
  logic [15:0] prog_word = 16'h0000;
  logic [15:0] tos, nos, disp;

  int checks = 0;
  int errors = 0;
  int m_tos = 0, m_nos = 0, m_disp = 0;

  always #2.5 clk = ~clk;

  tos_nos_datapath u_tos_nos_datapath (
    .clk (clk), .clr (clr), .t_load (t_load), .n_load (n_load),
    .disp_load (disp_load), .src_sel (src_sel), .func_code (func_code),
    .switches (switches), .prog_word (prog_word),
    .tos (tos), .nos (nos), .disp (disp)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "tos", int'(tos), m_tos);
    check(tag, "nos", int'(nos), m_nos);
    check(tag, "disp", int'(disp), m_disp);
  endtask

  // one clock: drive at the falling edge, compare at the next falling edge
  task automatic step(input logic tl, input logic nl, input logic dl, input logic [1:0] sel,
                      input logic [5:0] fc, input logic [7:0] sw, input logic [15:0] pw,
                      input string tag);
    int res, nt, nn, nd;
    t_load = tl; n_load = nl; disp_load = dl; src_sel = sel;
    func_code = fc; switches = sw; prog_word = pw;
    case (fc)
      6'h10:   res = (m_tos + m_nos) % 65536;
      6'h12:   res = (m_tos + 1) % 65536;
      6'h18:   res = (m_tos * 2) % 65536;
      6'h1C:   res = 65535 - m_tos;
      default: res = m_tos;
    endcase
    case (sel)
      2'b00:   nt = res;
      2'b01:   nt = int'(sw);
      2'b10:   nt = int'(pw);
      default: nt = m_nos;
    endcase
    nt = tl ? nt : m_tos;
    nn = nl ? m_tos : m_nos;
    nd = dl ? m_tos : m_disp;
    @(posedge clk);
    @(negedge clk);
    m_tos = nt; m_nos = nn; m_disp = nd;
    compare_all(tag);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1");
    clr = 1'b0;
    // switches 0x3B, double, dup, double, double, add, display
    step(1, 0, 0, 2'b01, 6'h00, 8'h3B, 16'h0000, "R4");
    step(1, 0, 0, 2'b00, 6'h18, 8'h00, 16'h0000, "R8");
    step(0, 1, 0, 2'b00, 6'h00, 8'h00, 16'h0000, "R2");
    step(1, 0, 0, 2'b00, 6'h18, 8'h00, 16'h0000, "R8");
    step(1, 0, 0, 2'b00, 6'h18, 8'h00, 16'h0000, "R8");
    step(1, 0, 0, 2'b00, 6'h10, 8'h00, 16'h0000, "R7");
    check("R7", "tos 0x24E", int'(tos), 16'h024E);
    step(0, 0, 1, 2'b00, 6'h00, 8'h00, 16'h0000, "R12");
    check("R12", "disp 0x24E", int'(disp), 16'h024E);
    // idle cycles with changing inputs: everything holds
    step(0, 0, 0, 2'b10, 6'h10, 8'hFF, 16'hBEEF, "R3");
    step(0, 0, 0, 2'b01, 6'h1C, 8'hA5, 16'h1234, "R3");
    // program word and NOS sources
    step(1, 0, 0, 2'b10, 6'h00, 8'h00, 16'hFFFF, "R5");
    step(1, 0, 0, 2'b11, 6'h00, 8'h00, 16'h0000, "R6");
    // add wrap: T=0xFFFF, N=0xFFFF -> 0xFFFE
    step(1, 0, 0, 2'b10, 6'h00, 8'h00, 16'hFFFF, "R5");
    step(0, 1, 0, 2'b00, 6'h00, 8'h00, 16'h0000, "R2");
    step(1, 0, 0, 2'b00, 6'h10, 8'h00, 16'h0000, "R7");
    check("R7", "wrap", int'(tos), 16'hFFFE);
    // increment wrap
    step(1, 0, 0, 2'b10, 6'h00, 8'h00, 16'hFFFF, "R5");
    step(1, 0, 0, 2'b00, 6'h12, 8'h00, 16'h0000, "R9");
    check("R9", "inc wrap", int'(tos), 0);
    step(1, 0, 0, 2'b00, 6'h12, 8'h00, 16'h0000, "R9");
    // invert and double dropping the top bit
    step(1, 0, 0, 2'b10, 6'h00, 8'h00, 16'hA55A, "R5");
    step(1, 0, 0, 2'b00, 6'h1C, 8'h00, 16'h0000, "R10");
    check("R10", "invert", int'(tos), 16'h5AA5);
    step(1, 0, 0, 2'b10, 6'h00, 8'h00, 16'h8001, "R5");
    step(1, 0, 0, 2'b00, 6'h18, 8'h00, 16'h0000, "R8");
    check("R8", "top bit dropped", int'(tos), 16'h0002);
    // other function codes leave T unchanged
    for (int c = 0; c < 64; c++) begin
      if (c != 16 && c != 18 && c != 24 && c != 28)
        step(1, 0, 0, 2'b00, 6'(c), 8'h00, 16'h0000, "R11");
    end
    // simultaneous loads: N gets old T, T gets switches
    step(1, 1, 0, 2'b01, 6'h00, 8'hC3, 16'h0000, "R13");
    check("R13", "nos old tos", int'(nos), 16'h0002);
    step(1, 1, 1, 2'b00, 6'h10, 8'h00, 16'h0000, "R13");
    // asynchronous clear between edges
    #1 clr = 1'b1;
    #0.5;
    m_tos = 0; m_nos = 0; m_disp = 0;
    compare_all("R1");
    @(negedge clk);
    compare_all("R1");
    clr = 1'b0;
    step(1, 0, 0, 2'b01, 6'h00, 8'h80, 16'h0000, "R4");
    check("R4", "zero ext", int'(tos), 16'h0080);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule